// File: doc/BRIEF.md
# Four-Lane Alignment-Column Deskew

This block lines up four receive lanes that arrive with different delays. Each lane carries one decoded code group per cycle: an 8-bit value, a control flag and a valid strobe. The transmitter places an alignment character on all four lanes in the same cycle. The medium and the independent clock recovery of each lane shift those characters relative to one another. The block removes that shift so that the four outputs show each transmitted column together.

Each lane has a 16-word FIFO. A lane starts writing its FIFO on the cycle it presents the alignment character. A single controller reads all four FIFOs together once every lane has written its alignment character. The controller is a three-state machine:
- **HUNT**: lanes arm and write.
- **LOCKED**: all lanes read in step, and `aligned` is high.
- **PURGE**: a one-cycle flush.

Its transitions are:
- HUNT→LOCKED when every lane is armed.
- HUNT→PURGE when an armed lane writes into a full FIFO.
- LOCKED→PURGE when a read column carries the alignment character on some lanes but not all, or when a FIFO overflows.
- PURGE→HUNT always.
- Any state→HUNT, with the FIFOs emptied, while deskew is disabled.

When deskew is disabled, the lanes pass straight through one register stage.

Top module: `quad_lane_deskew`

## Requirements
- R1: The alignment character is a word with valid=1, control flag=1 and value 0x7C. In lane i, the value occupies bits [8i+7:8i] of the data buses. The first column read after locking shows this character on all four lanes.
- R2: A lane stores words from the cycle it presents the alignment character onward. Words before that are dropped. Output column n holds, on each lane, the n-th word after that lane's alignment character.
- R3: All four lanes read in the same cycle. The first column appears on the outputs with every `out_valid` bit high, one clock edge after the edge that sampled the last lane's alignment character. The following columns appear one per edge while all lanes keep delivering words.
- R4: Each lane FIFO holds 16 words. A spread of up to 15 cycles between the earliest and the latest alignment character still locks.
- R5: `aligned` rises at the clock edge that samples the last lane's alignment character.
- R6: In HUNT, a write by an armed lane into its full FIFO forces PURGE for one cycle. PURGE empties all FIFOs, disarms all lanes and ignores all inputs, and `aligned` stays low. With a spread of 16 or more cycles, the block never locks.
- R7: In LOCKED, a read column with the alignment character on some lanes but not all drops `aligned` at the same edge that column reaches the outputs. The block then purges and hunts again. A later simultaneous column locks again.
- R8: While `deskew_en` is low, each output equals the corresponding input one edge earlier, `aligned` is low, and the FIFOs are emptied.
- R9: Synchronous reset clears `aligned` and `out_valid` and empties the FIFOs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| deskew_en | input | 1 | 1 = deskew active, 0 = registered pass-through |
| in_data | input | 32 | Lane values, lane i in bits [8i+7:8i] |
| in_ctrl | input | 4 | Per-lane control flag |
| in_valid | input | 4 | Per-lane word strobe |
| out_data | output | 32 | Aligned lane values, same packing as `in_data` |
| out_ctrl | output | 4 | Aligned control flags |
| out_valid | output | 4 | High on lanes holding a read (or passed-through) word |
| aligned | output | 1 | High while the four lanes are locked |

## Verification
Let T be the edge that samples the latest alignment character. `aligned` is due at edge T, and output column n is due at edge T+1+n. A mixed column drops `aligned` at the same edge it appears. Pass-through words are due one edge after they are sampled. Reset takes effect at the first edge with reset high.

The bench drives its inputs on falling edges and compares at the next falling edge, against the values the rising edge in between must have produced. For each skew pattern it derives T and the expected column index directly from the lane delays.

// File: rtl/deskew_pkg.sv
package deskew_pkg;
    localparam int CG_BITS = 8;
    localparam logic [CG_BITS-1:0] ALIGN_CHAR = 8'h7C;

    typedef struct packed {
        logic                ctrl;
        logic [CG_BITS-1:0]  data;
    } cg_t;

    typedef enum logic [1:0] {
        ST_HUNT   = 2'd0,
        ST_LOCKED = 2'd1,
        ST_PURGE  = 2'd2
    } dsk_state_t;
endpackage

// File: rtl/deskew_lane_fifo.sv
module deskew_lane_fifo #(
    parameter int W     = 9,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flush,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST  = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CFULL = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign full    = (cnt == CFULL);
    assign empty   = (cnt == '0);
    assign do_pop  = pop & ~empty;
    assign do_push = push & (~full | do_pop);
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= CFULL) else $error("fifo count beyond depth"); // R4
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        flush |=> empty) else $error("flush left words"); // R9
endmodule

// File: rtl/deskew_ctrl.sv
module deskew_ctrl
    import deskew_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [LANES-1:0] hit,
    input  logic [LANES-1:0] vld,
    input  logic [LANES-1:0] full,
    input  logic [LANES-1:0] empty,
    input  logic [LANES-1:0] head_mark,
    output logic [LANES-1:0] wr,
    output logic             rd,
    output logic             flush,
    output logic             aligned
);
    dsk_state_t       st, nxt;
    logic [LANES-1:0] armed, arm_now;
    logic             ovf, skewed;

    assign arm_now = armed | hit;
    assign aligned = (st == ST_LOCKED);

    // state register
    always_ff @(posedge clk) begin
        if (rst) st <= ST_HUNT;
        else     st <= nxt;
    end

    always_ff @(posedge clk) begin
        if (rst || !en || st != ST_HUNT || nxt != ST_HUNT) armed <= '0;
        else                                               armed <= arm_now;
    end

    // next state and per-cycle controls
    always_comb begin
        nxt    = st;
        wr     = '0;
        rd     = 1'b0;
        flush  = 1'b0;
        ovf    = 1'b0;
        skewed = 1'b0;
        unique case (st)
            ST_HUNT: begin
                wr  = vld & arm_now;
                ovf = |(wr & full);
                if (ovf)            nxt = ST_PURGE;
                else if (&arm_now)  nxt = ST_LOCKED;
            end
            ST_LOCKED: begin
                rd     = ~|empty;
                wr     = vld;
                ovf    = |(wr & full) & ~rd;
                skewed = rd & (|head_mark) & ~(&head_mark);
                if (ovf || skewed)  nxt = ST_PURGE;
            end
            ST_PURGE: begin
                flush = 1'b1;
                nxt   = ST_HUNT;
            end
            default: nxt = ST_HUNT;
        endcase
        if (!en) begin
            nxt   = ST_HUNT;
            wr    = '0;
            rd    = 1'b0;
            flush = 1'b1;
        end
    end

    AST_PURGE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        st == ST_PURGE |=> st == ST_HUNT && armed == '0) else $error("purge too long"); // R6
    AST_HUNT_OVF_PURGES: assert property (@(posedge clk) disable iff (rst)
        (en && st == ST_HUNT && |(vld & arm_now & full)) |=> st == ST_PURGE) else $error("overflow missed"); // R6
    AST_LOCK_NEEDS_ALL: assert property (@(posedge clk) disable iff (rst)
        $rose(aligned) |-> $past(&(armed | hit))) else $error("locked early"); // R5
endmodule

// File: rtl/quad_lane_deskew.sv
module quad_lane_deskew
    import deskew_pkg::*;
#(
    parameter int LANES = 4,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       deskew_en,
    input  logic [LANES*CG_BITS-1:0]   in_data,
    input  logic [LANES-1:0]           in_ctrl,
    input  logic [LANES-1:0]           in_valid,
    output logic [LANES*CG_BITS-1:0]   out_data,
    output logic [LANES-1:0]           out_ctrl,
    output logic [LANES-1:0]           out_valid,
    output logic                       aligned
);
    localparam int WW = $bits(cg_t);

    logic [LANES-1:0] hit, full, empty, head_mark, wr;
    logic             rd, flush;

    deskew_ctrl #(.LANES(LANES)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .en        (deskew_en),
        .hit       (hit),
        .vld       (in_valid),
        .full      (full),
        .empty     (empty),
        .head_mark (head_mark),
        .wr        (wr),
        .rd        (rd),
        .flush     (flush),
        .aligned   (aligned)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        cg_t in_w, head;
        assign in_w.ctrl    = in_ctrl[i];
        assign in_w.data    = in_data[i*CG_BITS +: CG_BITS];
        assign hit[i]       = in_valid[i] & in_w.ctrl & (in_w.data == ALIGN_CHAR);
        assign head_mark[i] = head.ctrl & (head.data == ALIGN_CHAR);

        deskew_lane_fifo #(.W(WW), .DEPTH(DEPTH)) u_fifo (
            .clk   (clk),
            .rst   (rst),
            .flush (flush),
            .push  (wr[i]),
            .pop   (rd),
            .din   (in_w),
            .dout  (head),
            .full  (full[i]),
            .empty (empty[i])
        );

        // output stage: FIFO head when deskewing, straight input otherwise
        always_ff @(posedge clk) begin
            if (rst) begin
                out_valid[i]                   <= 1'b0;
                out_ctrl[i]                    <= 1'b0;
                out_data[i*CG_BITS +: CG_BITS] <= '0;
            end else if (!deskew_en) begin
                out_valid[i]                   <= in_valid[i];
                out_ctrl[i]                    <= in_w.ctrl;
                out_data[i*CG_BITS +: CG_BITS] <= in_w.data;
            end else begin
                out_valid[i] <= rd;
                if (rd) begin
                    out_ctrl[i]                    <= head.ctrl;
                    out_data[i*CG_BITS +: CG_BITS] <= head.data;
                end
            end
        end
    end

    AST_COLUMN_TOGETHER: assert property (@(posedge clk) disable iff (rst)
        rd |=> (!deskew_en || &out_valid)) else $error("lanes read apart"); // R3
    AST_BYPASS_UNLOCKED: assert property (@(posedge clk) disable iff (rst)
        !deskew_en |=> !aligned) else $error("locked in bypass"); // R8
endmodule

// File: tb/quad_lane_deskew_test.sv
`timescale 1ns/1ps
module quad_lane_deskew_test;
    localparam int L = 4;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           deskew_en = 1'b1;
    logic [L*8-1:0] in_data = '0;
    logic [L-1:0]   in_ctrl = '0;
    logic [L-1:0]   in_valid = '0;
    logic [L*8-1:0] out_data;
    logic [L-1:0]   out_ctrl, out_valid;
    logic           aligned;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    int dly [L];
    int pm_idx = -1;
    int m2_idx = -1;

    quad_lane_deskew uut (
        .clk(clk), .rst(rst), .deskew_en(deskew_en),
        .in_data(in_data), .in_ctrl(in_ctrl), .in_valid(in_valid),
        .out_data(out_data), .out_ctrl(out_ctrl), .out_valid(out_valid),
        .aligned(aligned)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // transmitted word n on lane k: {ctrl, value}
    function automatic logic [8:0] word(input int k, input int n);
        if (n < 0) return {1'b1, 8'hBC};
        if (n == 0 || n == m2_idx) return {1'b1, 8'h7C};
        if (n == pm_idx && k != L-1) return {1'b1, 8'h7C};
        return {1'b0, 8'((n*5 + k*3 + 1) & 255)};
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        deskew_en = 1'b1;
        in_valid = '1; in_ctrl = '1;
        for (int k = 0; k < L; k++) in_data[k*8 +: 8] = 8'hBC;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // one deskew run; lane k sees transmitted word n at edge n + dly[k]
    task automatic run(input bit lockable, input bit edge15, input int ncyc);
        int t = 0;
        for (int k = 0; k < L; k++) if (dly[k] > t) t = dly[k];
        for (int c = 0; c <= ncyc; c++) begin
            @(negedge clk);
            if (c > 0) begin
                int e = c - 1;
                int al = 0;
                int v = 0;
                int col = 0;
                string tg;
                tg = lockable ? (edge15 ? "R4" : "R5") : "R6";
                if (!lockable) begin
                    al = 0; v = 0;
                end else if (e < t) begin
                    al = 0; v = 0;
                end else if (pm_idx >= 0 && e == t + 1 + pm_idx) begin
                    al = 0; v = 1; col = pm_idx; tg = "R7";
                end else if (pm_idx < 0 || e < t + 1 + pm_idx) begin
                    al = 1; v = (e >= t + 1); col = e - t - 1;
                end else if (e < m2_idx + t) begin
                    al = 0; v = 0; tg = "R7";
                end else begin
                    al = 1; v = (e >= m2_idx + t + 1);
                    col = m2_idx + e - (m2_idx + t + 1); tg = "R7";
                end
                chk({tg, " aligned"}, int'(aligned), al);
                chk({lockable && !edge15 ? "R3" : tg, " valid"}, int'(out_valid), v ? 15 : 0);
                if (v) begin
                    for (int k = 0; k < L; k++) begin
                        logic [8:0] w = word(k, col);
                        string dt;
                        dt = edge15 ? "R4" : ((col == 0 || col == m2_idx) ? "R1" : "R2");
                        if (tg == "R7") dt = "R7";
                        chk({dt, " data"}, int'(out_data[k*8 +: 8]), int'(w[7:0]));
                        chk({dt, " ctrl"}, int'(out_ctrl[k]), int'(w[8]));
                    end
                end
            end
            for (int k = 0; k < L; k++) begin
                logic [8:0] w = word(k, c - dly[k]);
                in_valid[k] = 1'b1;
                in_ctrl[k] = w[8];
                in_data[k*8 +: 8] = w[7:0];
            end
        end
    endtask

    task automatic bypass_run(input int ncyc);
        logic [L*8-1:0] pd = '0;
        logic [L-1:0] pc = '0, pv = '0;
        for (int c = 0; c <= ncyc; c++) begin
            @(negedge clk);
            if (c > 0) begin
                chk("R8 aligned", int'(aligned), 0);
                chk("R8 data", int'(out_data), int'(pd));
                chk("R8 ctrl", int'(out_ctrl), int'(pc));
                chk("R8 valid", int'(out_valid), int'(pv));
            end
            deskew_en = 1'b0;
            for (int k = 0; k < L; k++) begin
                in_data[k*8 +: 8] = 8'((c*13 + k*29) & 255);
                in_ctrl[k] = ((c + k) % 3) == 0;
                in_valid[k] = ((c + k) % 2) == 0;
            end
            pd = in_data; pc = in_ctrl; pv = in_valid;
        end
        @(negedge clk);
        deskew_en = 1'b1;
    endtask

    initial begin
        // reset state
        do_reset();
        @(negedge clk);
        chk("R9 reset aligned", int'(aligned), 0);
        chk("R9 reset valid", int'(out_valid), 0);

        for (int s = 0; s <= 17; s++) begin
            for (int r = 0; r < L; r++) begin
                int pat [L];
                pat[0] = 0; pat[1] = s; pat[2] = s / 2; pat[3] = (s * 3) / 4;
                for (int k = 0; k < L; k++) dly[k] = pat[(k + r) % L];
                do_reset();
                if (s <= 15) begin
                    pm_idx = 6;
                    m2_idx = pm_idx + s + 6;
                    run(1'b1, s == 15, m2_idx + 2*s + 10);
                end else begin
                    pm_idx = -1; m2_idx = -1;
                    run(1'b0, 1'b0, 60);
                end
            end
        end

        // reset while locked
        dly[0] = 3; dly[1] = 0; dly[2] = 7; dly[3] = 5;
        pm_idx = -1; m2_idx = -1;
        do_reset();
        run(1'b1, 1'b0, 20);
        @(negedge clk);
        chk("R9 locked before reset", int'(aligned), 1);
        rst = 1'b1;
        @(negedge clk);
        chk("R9 aligned cleared", int'(aligned), 0);
        chk("R9 valid cleared", int'(out_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R9 stays unlocked", int'(aligned), 0);

        // pass-through, then deskew again without reset
        do_reset();
        run(1'b1, 1'b0, 15);
        bypass_run(12);
        dly[0] = 9; dly[1] = 2; dly[2] = 0; dly[3] = 4;
        run(1'b1, 1'b0, 30);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule